// File: doc/BRIEF.md
# User-Mode Address Relocation and Block Guard

This block sits on the address path between a processor and a memory made of two equal word banks. Requests are classed by a mode input. A supervisor-mode request goes to the supervisor bank with its address unchanged and no check is made. A user-mode request always goes to the user bank. The bank is divided into fixed-size blocks. The block number in the upper address bits is offset by a relocation value, wrapping at the bank size. Each user program can therefore be written as if its area started at address zero.

Before a user request reaches memory, the relocated block is compared against a lower and an upper physical block bound. When the block lies outside them, the access is cancelled: nothing is written and the read data is forced to zero. A sticky violation flag then records the event, and only the supervisor can clear it. A run-time quantum counter counts down only in user-mode cycles. When it runs out it raises a time-up flag, which lets the supervisor bound how long each user runs.

The relocation value, the two bounds and the quantum are loaded through a small configuration port. That port is honoured only while the mode input says supervisor.

Top module: `usr_reloc_guard`

## Requirements
- R1: For a user-mode request, the memory address is the upper BW bits (block number) plus the relocation value modulo 2^BW, concatenated with the unchanged lower AW-BW offset bits, and mem_bank is 1 (user bank).
- R2: A user-mode request is legal only when its relocated block pb satisfies lower bound <= pb <= upper bound, both inclusive. If the lower bound exceeds the upper bound, no user block is legal.
- R3: On an illegal user request, viol_now is 1 in the same cycle, mem_en and mem_we are 0, and req_rdata is zero.
- R4: viol_sticky becomes 1 on the clock edge that ends a cycle with viol_now set. It stays 1 through later legal or supervisor requests. It clears only on an accepted configuration write.
- R5: A supervisor-mode request drives mem_en, mem_bank 0 and mem_addr equal to req_addr, with no bound check and no violation, even when the address lies outside the user bounds.
- R6: A configuration write (cfg_we) is accepted only when req_super is 1. cfg_sel selects the target: 0 = relocation value, 1 = lower bound, 2 = upper bound, 3 = quantum (cfg_data[BW-1:0] for blocks, full cfg_data for the quantum). A write with req_super 0 changes nothing.
- R7: An accepted register load takes effect for requests from the next cycle on.
- R8: Loading quantum N clears time_up. Each clock edge with req_super 0 decrements a nonzero count, and time_up becomes 1 on the edge that takes the count from 1 to 0. Edges with req_super 1 do not count, and time_up then stays set until the next quantum load.
- R9: After reset, the relocation value, both bounds and the quantum are 0, and viol_sticky and time_up are 0. Only user block 0 is then legal.
- R10: For a legal user request or any supervisor request, req_rdata equals mem_rdata, mem_wdata equals req_wdata, and mem_we equals req_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | Current mode: 1 = supervisor, 0 = user |
| req_addr | input | AW | Logical word address |
| req_wdata | input | DW | Write data from the processor |
| req_rdata | output | DW | Read data to the processor, zero when cancelled |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_data | input | TW | Configuration value |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_bank | output | 1 | Bank select: 1 = user bank, 0 = supervisor bank |
| mem_addr | output | AW | Word address within the selected bank |
| mem_wdata | output | DW | Write data to memory |
| mem_rdata | input | DW | Read data from memory |
| viol_now | output | 1 | Current request is a cancelled user access |
| viol_sticky | output | 1 | Violation seen since the last configuration write |
| time_up | output | 1 | User quantum exhausted |

## Verification
The hardest conditions to reach from the ports are those where a relocated block sits exactly on a bound after wrapping past the top of the bank. Random block numbers and relocation values seldom land there. The stimulus therefore chooses the logical block from the bound minus the relocation value, and probes one block inside and one block outside each bound. It does this with a relocation value that forces the wrap, and also with the lower bound set above the upper bound. Random traffic follows, with a mix of modes, periodic reloads issued in both modes, and quantum loads. The stickiness of the violation flag and the pausing of the quantum during supervisor cycles are checked on every request against a model kept in the bench.

// File: rtl/usr_reloc_pkg.sv
package usr_reloc_pkg;
  // Configuration target select codes
  typedef enum logic [1:0] {
    SEL_RELOC = 2'd0,
    SEL_LO    = 2'd1,
    SEL_HI    = 2'd2,
    SEL_QUANT = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/usr_reloc_regs.sv
module usr_reloc_regs
  import usr_reloc_pkg::*;
#(
  parameter int BW = 7,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ok,
  input  logic [1:0]    cfg_sel,
  input  logic [TW-1:0] cfg_data,
  output logic [BW-1:0] reloc_q,
  output logic [BW-1:0] lo_q,
  output logic [BW-1:0] hi_q,
  output logic          quant_load,
  output logic [TW-1:0] quant_val
);
  cfg_sel_e sel;
  assign sel        = cfg_sel_e'(cfg_sel);
  assign quant_load = cfg_ok && (sel == SEL_QUANT);
  assign quant_val  = cfg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloc_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (cfg_ok) begin
      unique case (sel)
        SEL_RELOC: reloc_q <= cfg_data[BW-1:0];
        SEL_LO:    lo_q    <= cfg_data[BW-1:0];
        SEL_HI:    hi_q    <= cfg_data[BW-1:0];
        SEL_QUANT: ;
      endcase
    end
  end
endmodule

// File: rtl/usr_reloc_xlate.sv
module usr_reloc_xlate #(
  parameter int AW = 15,
  parameter int BW = 7
) (
  input  logic [AW-1:0] log_addr,
  input  logic [BW-1:0] reloc,
  input  logic [BW-1:0] lo,
  input  logic [BW-1:0] hi,
  output logic [AW-1:0] user_addr,
  output logic          blk_legal
);
  localparam int OW = AW - BW;

  function automatic logic [BW-1:0] phys_blk(logic [BW-1:0] vb, logic [BW-1:0] rel);
    logic [BW-1:0] s;
    s = vb + rel;
    return s;
  endfunction

  function automatic logic blk_in(logic [BW-1:0] pb, logic [BW-1:0] l, logic [BW-1:0] h);
    return (pb >= l) && (pb <= h);
  endfunction

  logic [BW-1:0] pblk;
  assign pblk      = phys_blk(log_addr[AW-1:OW], reloc);
  assign user_addr = {pblk, log_addr[OW-1:0]};
  assign blk_legal = blk_in(pblk, lo, hi);
endmodule

// File: rtl/usr_reloc_timer.sv
module usr_reloc_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          time_up
);
  logic [TW-1:0] cnt_q;
  logic          cnt_live;
  logic          last_tick;
  assign cnt_live  = run && (cnt_q != '0);
  assign last_tick = cnt_live && (cnt_q == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      time_up <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      time_up <= 1'b0;
    end else if (cnt_live) begin
      cnt_q <= cnt_q - TW'(1);
      if (last_tick) time_up <= 1'b1;
    end
  end
endmodule

// File: rtl/usr_reloc_guard.sv
module usr_reloc_guard
  import usr_reloc_pkg::*;
#(
  parameter int AW = 15,
  parameter int BW = 7,
  parameter int DW = 36,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_super,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_rdata,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [TW-1:0] cfg_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic          mem_bank,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          viol_now,
  output logic          viol_sticky,
  output logic          time_up
);
  // Named internal events
  logic          cfg_ok;
  logic [BW-1:0] reloc_q, lo_q, hi_q;
  logic          quant_load;
  logic [TW-1:0] quant_val;
  logic [AW-1:0] user_addr;
  logic          blk_legal;

  assign cfg_ok = cfg_we && req_super;

  usr_reloc_regs #(.BW(BW), .TW(TW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .reloc_q(reloc_q), .lo_q(lo_q), .hi_q(hi_q),
    .quant_load(quant_load), .quant_val(quant_val)
  );

  usr_reloc_xlate #(.AW(AW), .BW(BW)) xlate_i (
    .log_addr(req_addr), .reloc(reloc_q), .lo(lo_q), .hi(hi_q),
    .user_addr(user_addr), .blk_legal(blk_legal)
  );

  usr_reloc_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(quant_load), .load_val(quant_val),
    .run(!req_super), .time_up(time_up)
  );

  assign viol_now  = req_valid && !req_super && !blk_legal;
  assign mem_en    = req_valid && !viol_now;
  assign mem_we    = mem_en && req_write;
  assign mem_bank  = !req_super;
  assign mem_addr  = req_super ? req_addr : user_addr;
  assign mem_wdata = req_wdata;
  assign req_rdata = mem_en ? mem_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          viol_sticky <= 1'b0;
    else if (cfg_ok)     viol_sticky <= 1'b0;
    else if (viol_now)   viol_sticky <= 1'b1;
  end
endmodule

// File: rtl/usr_reloc_guard_chk.sv
module usr_reloc_guard_chk #(
  parameter int AW = 15,
  parameter int BW = 7,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_super,
  input logic [AW-1:0] req_addr,
  input logic          cfg_we,
  input logic          cfg_ok,
  input logic [BW-1:0] reloc_q,
  input logic          mem_en,
  input logic          mem_we,
  input logic          mem_bank,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] req_rdata,
  input logic          viol_now,
  input logic          viol_sticky,
  input logic          time_up
);
  localparam int OW = AW - BW;

  AST_VIOL_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |-> (!mem_en && !mem_we && req_rdata == '0)); // R3

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && req_write)); // R10

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> viol_sticky); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_sticky && !cfg_ok) |=> viol_sticky); // R4

  AST_SUPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super) |-> (mem_en && !mem_bank && mem_addr == req_addr && !viol_now)); // R5

  AST_USER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_super && mem_en) |-> (mem_bank && mem_addr[OW-1:0] == req_addr[OW-1:0])); // R1

  AST_USER_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !req_super) |=> $stable(reloc_q)); // R6

  AST_TIME_UP_USER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(time_up) |-> $past(!req_super)); // R8
endmodule

bind usr_reloc_guard usr_reloc_guard_chk #(.AW(AW), .BW(BW), .DW(DW)) chk_i (.*);

// File: tb/usr_reloc_guard_tb_top.sv
`timescale 1ns/1ps
module usr_reloc_guard_tb_top;
  localparam int AW = 15, BW = 7, DW = 36, TW = 16, OW = AW - BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_super = 1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_rdata, mem_wdata, mem_rdata;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [TW-1:0] cfg_data = '0;
  logic mem_en, mem_we, mem_bank, viol_now, viol_sticky, time_up;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] rdm(logic b, logic [AW-1:0] a);
    return {b, 5'h15, a, ~a};
  endfunction
  assign mem_rdata = rdm(mem_bank, mem_addr);

  usr_reloc_guard #(.AW(AW), .BW(BW), .DW(DW), .TW(TW)) dut_i (.*);

  int n_cmp = 0, n_mis = 0;
  bit done = 0;

  // Bench model, updated from the requirements at each edge
  logic [BW-1:0] m_rel = 0, m_lo = 0, m_hi = 0;
  logic [TW-1:0] m_cnt = 0;
  bit m_viol = 0, m_tu = 0;

  function automatic logic [BW-1:0] pblk_of(logic [AW-1:0] a);
    return BW'(a[AW-1:OW] + m_rel);
  endfunction
  function automatic bit legal_of(logic [AW-1:0] a);
    logic [BW-1:0] p;
    p = pblk_of(a);
    return (m_lo <= p) && (p <= m_hi);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_lo = 0; m_hi = 0; m_cnt = 0; m_viol = 0; m_tu = 0;
    end else begin
      bit ok, illegal;
      ok = cfg_we && req_super;
      illegal = req_valid && !req_super && !legal_of(req_addr);
      if (ok) m_viol = 0; else if (illegal) m_viol = 1;
      if (ok && cfg_sel == 2'd3) begin m_cnt = cfg_data; m_tu = 0; end
      else if (!req_super && m_cnt != 0) begin
        if (m_cnt == 1) m_tu = 1;
        m_cnt = m_cnt - 1;
      end
      if (ok) case (cfg_sel)
        2'd0: m_rel = cfg_data[BW-1:0];
        2'd1: m_lo  = cfg_data[BW-1:0];
        2'd2: m_hi  = cfg_data[BW-1:0];
        default: ;
      endcase
    end
  end

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_state();
    chk(viol_sticky == m_viol, "R4", "viol_sticky", 64'(viol_sticky), 64'(m_viol));
    chk(time_up == m_tu, "R8", "time_up", 64'(time_up), 64'(m_tu));
  endtask

  task automatic acc(bit s, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [AW-1:0] ea;
    bit en;
    logic [DW-1:0] er;
    @(negedge clk);
    chk_state();
    req_valid = 1; req_super = s; req_write = w; req_addr = a; req_wdata = d;
    #1;
    en = s || legal_of(a);
    ea = s ? a : {pblk_of(a), a[OW-1:0]};
    er = en ? rdm(!s, ea) : '0;
    chk(mem_en == en, "R2", "mem_en", 64'(mem_en), 64'(en));
    chk(viol_now == !en, "R3", "viol_now", 64'(viol_now), 64'(!en));
    chk(mem_we == (en && w), "R3", "mem_we", 64'(mem_we), 64'(en && w));
    chk(mem_bank == !s, s ? "R5" : "R1", "mem_bank", 64'(mem_bank), 64'(!s));
    if (en) begin
      chk(mem_addr == ea, s ? "R5" : "R1", "mem_addr", 64'(mem_addr), 64'(ea));
      chk(mem_wdata == d, "R10", "mem_wdata", 64'(mem_wdata), 64'(d));
    end
    chk(req_rdata == er, en ? "R10" : "R3", "req_rdata", 64'(req_rdata), 64'(er));
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic cfg(bit s, logic [1:0] sel, logic [TW-1:0] v);
    @(negedge clk);
    chk_state();
    req_valid = 0; req_super = s; cfg_we = 1; cfg_sel = sel; cfg_data = v;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  function automatic logic [AW-1:0] mk(int blk, int off);
    return {BW'(blk), OW'(off)};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #12 rst_n = 1;
    // R9: reset state
    @(negedge clk);
    chk(viol_sticky == 0, "R9", "viol_sticky after reset", 64'(viol_sticky), 0);
    chk(time_up == 0, "R9", "time_up after reset", 64'(time_up), 0);
    acc(0, 0, mk(0, 8'h12), 0);          // R9: block 0 legal
    acc(0, 0, mk(1, 8'h12), 0);          // R9: block 1 illegal
    cfg(1, 2'd1, 0);                     // clears sticky (R4)
    // R6: user-mode load ignored
    cfg(0, 2'd0, 5);
    acc(0, 0, mk(0, 8'h34), 0);
    // R7/R1: wrap 120 + 20 = 12 within [10,15]
    cfg(1, 2'd0, 20); cfg(1, 2'd1, 10); cfg(1, 2'd2, 15);
    acc(0, 1, mk(120, 8'h44), 36'h123456789);
    // R2 boundaries
    acc(0, 0, mk(118, 1), 0);            // pb 10 legal
    acc(0, 0, mk(123, 2), 0);            // pb 15 legal
    acc(0, 1, mk(117, 3), 36'hABC);      // pb 9 illegal write (R3)
    acc(0, 0, mk(124, 4), 0);            // pb 16 illegal
    // R4: sticky holds across legal and supervisor requests
    acc(0, 0, mk(119, 5), 0);
    acc(1, 1, mk(100, 6), 36'h55);       // R5 supervisor out of bounds
    @(negedge clk);
    chk(viol_sticky == 1, "R4", "sticky held", 64'(viol_sticky), 1);
    cfg(1, 2'd0, 20);
    @(negedge clk);
    chk(viol_sticky == 0, "R4", "sticky cleared", 64'(viol_sticky), 0);
    // R2: lower above upper, nothing legal
    cfg(1, 2'd1, 20); cfg(1, 2'd2, 5);
    for (int i = 0; i < 6; i++) acc(0, 0, mk(i * 21, i), 0);
    // R8: quantum 6
    cfg(1, 2'd3, 6);
    req_super = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      chk(time_up == (k >= 6), "R8", "quantum run", 64'(time_up), 64'(k >= 6));
    end
    // R8: supervisor cycles pause the count
    cfg(1, 2'd3, 3);
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk(time_up == 0, "R8", "paused in supervisor", 64'(time_up), 0);
    end
    req_super = 0;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk(time_up == (k >= 3), "R8", "resume", 64'(time_up), 64'(k >= 3));
    end
    // Random traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) cfg($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
                      TW'($urandom_range(0, 40)));
      else if (r == 1) cfg(1, 2'($urandom_range(0, 2)), TW'($urandom_range(0, 127)));
      else acc($urandom_range(0, 3) == 0, 1'($urandom_range(0, 1)),
               AW'($urandom), {4'h0, 32'($urandom)});
    end
    @(negedge clk);
    chk_state();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule